// File: doc/BRIEF.md
# Serial Flash Command Gate

This block is the serial-interface front end of a NOR flash model. Chip select, serial clock and data-in are sampled in the system clock domain, and the block detects the serial clock edges itself. It assembles the opcode, a 24-bit address and any payload bytes. It holds the write-enable latch, the block-protect field and the status-lock bit. When chip select goes high, it decides whether the frame that just ended may modify the part.

A page program lands in a page buffer that starts each frame filled with ones. When the frame is accepted, the buffer is ANDed into one page of a small internal array, so programming can only clear bits. Each accepted modifying command, including a status write, is handed to an external cycle sequencer as a one-cycle start pulse and an operation code. The write-in-progress flag then stays set until the sequencer answers with a done pulse. Status reads and array reads stream their bytes back on the serial output in SPI mode 0.

Top module: `sflash_cmd_gate`

## Requirements
- R1: After reset the status byte reads 00h. Opcode 06h sets the write-enable latch (status bit 1). Opcode 04h clears it.
- R2: Program (02h), erase (20h, 52h, D8h, C7h) and status write (01h) frames are dropped when the write-enable latch is clear.
- R3: A modifying frame whose count of serial clock rising edges is not a multiple of eight is dropped, and the latch keeps its value.
- R4: Page program data bytes go to consecutive offsets inside the 256-byte page of the address and wrap to the page start. When more than 256 bytes arrive, the later bytes overwrite the earlier ones.
- R5: Bytes read FFh after reset, and an accepted program ANDs the new data into the stored byte.
- R6: An accepted command raises `seq_start` for exactly one cycle with `seq_op` set to 0 (status write), 1 (program), 2 (20h), 3 (52h), 4 (D8h) or 5 (C7h). Write-in-progress (status bit 0) then reads 1 until `seq_done`, and `seq_done` clears both write-in-progress and the latch.
- R7: While write-in-progress is set, every opcode other than the status read (05h) and the array read (03h) has no effect.
- R8: After opcode B9h the block ignores every opcode except ABh, which wakes it. Status reads return zeros while it is asleep.
- R9: An accepted status write loads the protect field from data bits 5..2 and the lock bit from data bit 7. The write is refused while `wp_n` is low and the lock bit is set.
- R10: A non-zero protect field n guards the top min(256·2^(n-1), array size) bytes of the array. Program or erase aimed there, and chip erase (C7h) with any non-zero field, are dropped.
- R11: Opcode 05h returns the status byte {lock, 0, protect[3:0], latch, wip}, most significant bit first. The output changes after falling serial clock edges, and the byte is repeated for as long as clocks continue.
- R12: Opcode 03h followed by a 3-byte address returns array bytes from that address onward, one byte per eight clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock (mode 0) |
| mosi | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data out |
| seq_start | output | 1 | One-cycle start to the cycle sequencer |
| seq_op | output | 3 | Operation code for the sequencer |
| seq_done | input | 1 | Sequencer completion pulse |

## Verification
A latch or write-in-progress flag left in the wrong state shows up on the next status read as a wrong bit. It also changes whether the next modifying frame produces a start pulse, which the sequencer monitor flags at the chip-select rise of that frame. A wrong page offset, wrap or protect boundary leaves a stored byte with a value that differs from the AND of all data written to it, and the next array read shows it. Because every command ends with a status or array read, a bad state is caught within one or two frames of where it arises.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_WRSR = 8'h01;
    localparam logic [7:0] OPC_PP   = 8'h02;
    localparam logic [7:0] OPC_READ = 8'h03;
    localparam logic [7:0] OPC_SE   = 8'h20;
    localparam logic [7:0] OPC_HBE  = 8'h52;
    localparam logic [7:0] OPC_BE   = 8'hD8;
    localparam logic [7:0] OPC_CE   = 8'hC7;
    localparam logic [7:0] OPC_DP   = 8'hB9;
    localparam logic [7:0] OPC_RDI  = 8'hAB;

    typedef enum logic [2:0] {
        SEQ_WRSR = 3'd0,
        SEQ_PP   = 3'd1,
        SEQ_SE   = 3'd2,
        SEQ_HBE  = 3'd3,
        SEQ_BE   = 3'd4,
        SEQ_CE   = 3'd5
    } seq_op_e;
endpackage

// File: rtl/sfg_spi_rx.sv
module sfg_spi_rx #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             mosi,
    output logic             frame_start,
    output logic             frame_end,
    output logic             sck_fall,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             byte_done,
    output logic [7:0]       byte_val
);
    typedef struct packed {
        logic [2:0]       cs;
        logic [2:0]       sck;
        logic [1:0]       dat;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       sr;
        logic             bdone;
    } rx_t;

    rx_t rx_q, rx_d;
    logic active, rise;
    logic [CNT_W-1:0] cnt_inc;

    assign active      = ~rx_q.cs[1];
    assign rise        = active & rx_q.sck[1] & ~rx_q.sck[2];
    assign sck_fall    = active & ~rx_q.sck[1] & rx_q.sck[2];
    assign frame_start = rx_q.cs[2] & ~rx_q.cs[1];
    assign frame_end   = ~rx_q.cs[2] & rx_q.cs[1];
    assign cnt_inc     = rx_q.cnt + CNT_W'(1);

    always_comb begin
        rx_d       = rx_q;
        rx_d.cs    = {rx_q.cs[1:0], cs_n};
        rx_d.sck   = {rx_q.sck[1:0], sclk};
        rx_d.dat   = {rx_q.dat[0], mosi};
        rx_d.bdone = 1'b0;
        if (frame_start) begin
            rx_d.cnt = '0;
            rx_d.sr  = '0;
        end else if (rise) begin
            rx_d.cnt   = cnt_inc;
            rx_d.sr    = {rx_q.sr[6:0], rx_q.dat[1]};
            rx_d.bdone = (cnt_inc[2:0] == 3'd0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q     <= '0;
            rx_q.cs  <= 3'b111;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign bit_cnt   = rx_q.cnt;
    assign byte_done = rx_q.bdone;
    assign byte_val  = rx_q.sr;
endmodule

// File: rtl/sfg_protect.sv
module sfg_protect #(
    parameter int MEM_BYTES  = 1024,
    parameter int PAGE_BYTES = 256,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic [3:0]    bp,
    input  logic [AW-1:0] addr,
    input  logic          whole_chip,
    output logic          blocked
);
    localparam logic [31:0] MEM_U  = 32'(MEM_BYTES);
    localparam logic [31:0] PAGE_U = 32'(PAGE_BYTES);

    logic [31:0] span;
    logic [31:0] addr_u;

    assign addr_u = 32'(addr);

    always_comb begin
        span = '0;
        if (bp != 4'd0) begin
            span = PAGE_U << (bp - 4'd1);
        end
        if (span > MEM_U) begin
            span = MEM_U;
        end
        blocked = (bp != 4'd0) && (whole_chip || (addr_u >= (MEM_U - span)));
    end
endmodule

// File: rtl/sfg_flash_mem.sv
module sfg_flash_mem #(
    parameter int MEM_BYTES  = 1024,
    parameter int PAGE_BYTES = 256,
    localparam int AW  = $clog2(MEM_BYTES),
    localparam int PW  = $clog2(PAGE_BYTES),
    localparam int PGW = AW - PW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           buf_clr,
    input  logic           buf_we,
    input  logic [PW-1:0]  buf_idx,
    input  logic [7:0]     buf_wdata,
    input  logic           commit,
    input  logic [PGW-1:0] commit_pg,
    input  logic [AW-1:0]  rd_addr,
    output logic [7:0]     rd_data
);
    logic [7:0] pbuf_q [PAGE_BYTES];
    logic [7:0] arr_q  [MEM_BYTES];

    // Page buffer: all ones at frame start, so untouched offsets leave the array alone.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) pbuf_q[i] <= 8'hFF;
        end else if (buf_clr) begin
            for (int i = 0; i < PAGE_BYTES; i++) pbuf_q[i] <= 8'hFF;
        end else if (buf_we) begin
            pbuf_q[buf_idx] <= buf_wdata;
        end
    end

    // Array: programming can only clear bits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) arr_q[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                arr_q[{commit_pg, PW'(i)}] <= arr_q[{commit_pg, PW'(i)}] & pbuf_q[i];
            end
        end
    end

    assign rd_data = arr_q[rd_addr];
endmodule

// File: rtl/sflash_cmd_gate.sv
module sflash_cmd_gate
    import sfg_pkg::*;
#(
    parameter int MEM_BYTES  = 1024,
    parameter int PAGE_BYTES = 256,
    parameter int CNT_W      = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       mosi,
    input  logic       wp_n,
    output logic       miso,
    output logic       seq_start,
    output logic [2:0] seq_op,
    input  logic       seq_done
);
    localparam int AW  = $clog2(MEM_BYTES);
    localparam int PW  = $clog2(PAGE_BYTES);
    localparam int PGW = AW - PW;

    typedef struct packed {
        logic          wel;
        logic          wip;
        logic          dp;
        logic [3:0]    bp;
        logic          srp;
        logic [7:0]    opc;
        logic [AW-1:0] addr;
        logic [3:0]    nbp;
        logic          nsrp;
        logic [PW-1:0] pidx;
        logic [AW-1:0] rptr;
        logic [7:0]    osr;
        logic          miso;
        logic          start;
        seq_op_e       op;
    } gate_t;

    gate_t st_q, st_d;

    logic             frame_start, frame_end, sck_fall, byte_done;
    logic [CNT_W-1:0] bit_cnt, bidx;
    logic [7:0]       byte_val, rd_data, status_now;
    logic             buf_we, commit, blocked;
    logic [PW-1:0]    buf_idx;
    logic [AW-1:0]    new_addr, rd_sel;
    logic             is_addr_cmd, aligned, has_op, gate_ok;

    sfg_spi_rx #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .frame_start(frame_start), .frame_end(frame_end), .sck_fall(sck_fall),
        .bit_cnt(bit_cnt), .byte_done(byte_done), .byte_val(byte_val)
    );

    sfg_flash_mem #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_mem (
        .clk(clk), .rst_n(rst_n), .buf_clr(frame_start), .buf_we(buf_we),
        .buf_idx(buf_idx), .buf_wdata(byte_val), .commit(commit),
        .commit_pg(st_q.addr[AW-1:PW]), .rd_addr(rd_sel), .rd_data(rd_data)
    );

    sfg_protect #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_prot (
        .bp(st_q.bp), .addr(st_q.addr), .whole_chip(st_q.opc == OPC_CE),
        .blocked(blocked)
    );

    assign bidx        = bit_cnt >> 3;
    assign new_addr    = AW'({st_q.addr, byte_val});
    assign status_now  = {st_q.srp, 1'b0, st_q.bp, st_q.wel, st_q.wip};
    assign is_addr_cmd = (st_q.opc == OPC_PP) || (st_q.opc == OPC_READ) ||
                         (st_q.opc == OPC_SE) || (st_q.opc == OPC_HBE) ||
                         (st_q.opc == OPC_BE);
    assign aligned     = (bit_cnt[2:0] == 3'd0);
    assign has_op      = (bit_cnt >= CNT_W'(8));
    assign gate_ok     = aligned && has_op && !st_q.wip && !st_q.dp;

    // Read pointer select: the address is complete on byte 4.
    always_comb begin
        rd_sel = st_q.rptr;
        if (byte_done && bidx == CNT_W'(4)) rd_sel = new_addr;
    end

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        buf_we     = 1'b0;
        buf_idx    = st_q.pidx;
        commit     = 1'b0;

        if (frame_start) st_d.opc = 8'h00;

        if (byte_done) begin
            if (bidx == CNT_W'(1)) begin
                st_d.opc = byte_val;
                if (byte_val == OPC_RDSR && !st_q.dp) st_d.osr = status_now;
            end else begin
                if (bidx <= CNT_W'(4) && is_addr_cmd) begin
                    st_d.addr = new_addr;
                    if (bidx == CNT_W'(4)) begin
                        st_d.pidx = new_addr[PW-1:0];
                        st_d.rptr = new_addr + AW'(1);
                    end
                end
                if (bidx == CNT_W'(2) && st_q.opc == OPC_WRSR) begin
                    st_d.nbp  = byte_val[5:2];
                    st_d.nsrp = byte_val[7];
                end
                if (bidx >= CNT_W'(5) && st_q.opc == OPC_PP) begin
                    buf_we    = 1'b1;
                    st_d.pidx = st_q.pidx + PW'(1);
                end
                if (st_q.opc == OPC_RDSR && !st_q.dp) st_d.osr = status_now;
                if (st_q.opc == OPC_READ && !st_q.dp && bidx >= CNT_W'(4)) begin
                    st_d.osr  = rd_data;
                    st_d.rptr = rd_sel + AW'(1);
                end
            end
        end

        if (sck_fall) begin
            st_d.miso = st_q.osr[7];
            st_d.osr  = {st_q.osr[6:0], 1'b0};
        end

        if (frame_end) begin
            st_d.miso = 1'b0;
            st_d.osr  = '0;
            if (has_op && st_q.opc == OPC_RDI && st_q.dp) st_d.dp = 1'b0;
            if (gate_ok) begin
                case (st_q.opc)
                    OPC_WREN: st_d.wel = 1'b1;
                    OPC_WRDI: st_d.wel = 1'b0;
                    OPC_DP:   st_d.dp  = 1'b1;
                    OPC_WRSR: begin
                        if (st_q.wel && bit_cnt >= CNT_W'(16) && !(st_q.srp && !wp_n)) begin
                            st_d.bp    = st_q.nbp;
                            st_d.srp   = st_q.nsrp;
                            st_d.wip   = 1'b1;
                            st_d.start = 1'b1;
                            st_d.op    = SEQ_WRSR;
                        end
                    end
                    OPC_PP: begin
                        if (st_q.wel && bit_cnt >= CNT_W'(40) && !blocked) begin
                            commit     = 1'b1;
                            st_d.wip   = 1'b1;
                            st_d.start = 1'b1;
                            st_d.op    = SEQ_PP;
                        end
                    end
                    OPC_SE, OPC_HBE, OPC_BE: begin
                        if (st_q.wel && bit_cnt == CNT_W'(32) && !blocked) begin
                            st_d.wip   = 1'b1;
                            st_d.start = 1'b1;
                            st_d.op    = (st_q.opc == OPC_SE)  ? SEQ_SE :
                                         (st_q.opc == OPC_HBE) ? SEQ_HBE : SEQ_BE;
                        end
                    end
                    OPC_CE: begin
                        if (st_q.wel && bit_cnt == CNT_W'(8) && !blocked) begin
                            st_d.wip   = 1'b1;
                            st_d.start = 1'b1;
                            st_d.op    = SEQ_CE;
                        end
                    end
                    default: ;
                endcase
            end
        end

        if (seq_done) begin
            st_d.wip = 1'b0;
            st_d.wel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miso      = st_q.miso;
    assign seq_start = st_q.start;
    assign seq_op    = st_q.op;

    a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start);
    a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (!st_q.wip && !st_q.wel));
    a_r2_wel_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> $past(st_q.wel));
    a_r7_idle_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> !$past(st_q.wip));
    a_r8_awake_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> !$past(st_q.dp));
    a_r9_locked_bp: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.srp && !wp_n) |=> ($stable(st_q.bp) && st_q.srp));
endmodule

// File: tb/sflash_cmd_gate_tb.sv
module sflash_cmd_gate_tb;
    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic seq_done = 1'b0;
    logic miso, seq_start;
    logic [2:0] seq_op;

    int errors = 0, checks = 0, busy_cnt = 0;
    logic [7:0] txb [300];
    logic [7:0] rxb [300];
    logic [2:0] exp_ops [$];
    logic [7:0] s;

    always #2.5 clk = ~clk;

    sflash_cmd_gate u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .wp_n(wp_n), .miso(miso), .seq_start(seq_start), .seq_op(seq_op),
        .seq_done(seq_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sequencer model and start monitor (scoreboard pop side).
    always @(negedge clk) begin
        seq_done <= 1'b0;
        if (rst_n && seq_start) begin
            checks++;
            if (exp_ops.size() == 0) begin
                errors++;
                $display("FAIL R6: actual=start op %0d expected=no start", seq_op);
            end else begin
                logic [2:0] e;
                e = exp_ops.pop_front();
                if (seq_op != e) begin
                    errors++;
                    $display("FAIL R6: actual=op %0d expected=op %0d", seq_op, e);
                end
            end
            busy_cnt = 600;
        end else if (busy_cnt > 0) begin
            busy_cnt = busy_cnt - 1;
            if (busy_cnt == 0) seq_done <= 1'b1;
        end
    end

    task automatic frame(input int nbytes, input int extra);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbytes * 8 + extra; i++) begin
            mosi = (i / 8 < nbytes) ? txb[i / 8][7 - i % 8] : 1'b0;
            repeat (8) @(negedge clk);
            rxb[i / 8][7 - i % 8] = miso;
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send1(input logic [7:0] op);
        txb[0] = op;
        frame(1, 0);
    endtask

    task automatic rdsr(output logic [7:0] v);
        txb[0] = 8'h05; txb[1] = 8'h00;
        frame(2, 0);
        v = rxb[1];
    endtask

    task automatic set_hdr(input logic [7:0] op, input logic [23:0] a);
        txb[0] = op; txb[1] = a[23:16]; txb[2] = a[15:8]; txb[3] = a[7:0];
    endtask

    task automatic rd(input logic [23:0] a, input int n);
        set_hdr(8'h03, a);
        for (int i = 0; i < n; i++) txb[4 + i] = 8'h00;
        frame(4 + n, 0);
    endtask

    task automatic wait_idle();
        repeat (700) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 reset miso", miso, 0);
        check("R6 reset start", seq_start, 0);
        rdsr(s); check("R1 reset status", s, 8'h00);

        send1(8'h06); rdsr(s); check("R1 latch set", s, 8'h02);
        send1(8'h04); rdsr(s); check("R1 latch cleared", s, 8'h00);

        // R2: program with latch clear
        set_hdr(8'h02, 24'h000010); txb[4] = 8'hA5; frame(5, 0);
        rd(24'h000010, 1); check("R2 R5 untouched byte", rxb[4], 8'hFF);

        send1(8'h06); exp_ops.push_back(3'd1);
        set_hdr(8'h02, 24'h000010); txb[4] = 8'hA5; txb[5] = 8'h3C; frame(6, 0);
        rdsr(s); check("R6 wip and latch", s, 8'h03);
        wait_idle();
        rdsr(s); check("R6 done clears", s, 8'h00);
        rd(24'h000010, 3);
        check("R12 R5 byte0", rxb[4], 8'hA5);
        check("R12 byte1", rxb[5], 8'h3C);
        check("R12 byte2", rxb[6], 8'hFF);

        send1(8'h06); exp_ops.push_back(3'd1);
        set_hdr(8'h02, 24'h000010); txb[4] = 8'h5A; frame(5, 0);
        wait_idle();
        rd(24'h000010, 1); check("R5 only clears bits", rxb[4], 8'h00);

        send1(8'h06); exp_ops.push_back(3'd1);
        set_hdr(8'h02, 24'h0001FE); txb[4] = 8'h11; txb[5] = 8'h22; txb[6] = 8'h33; frame(7, 0);
        wait_idle();
        rd(24'h0001FE, 2);
        check("R4 offset FE", rxb[4], 8'h11);
        check("R4 offset FF", rxb[5], 8'h22);
        rd(24'h000100, 1); check("R4 wrap to page start", rxb[4], 8'h33);

        send1(8'h06); exp_ops.push_back(3'd1);
        set_hdr(8'h02, 24'h000200);
        for (int i = 0; i < 256; i++) txb[4 + i] = ~8'(i);
        txb[260] = 8'h77;
        frame(261, 0);
        wait_idle();
        rd(24'h000200, 2);
        check("R4 last byte kept", rxb[4], 8'h77);
        check("R4 second offset", rxb[5], 8'hFE);

        send1(8'h06);
        set_hdr(8'h02, 24'h000300); txb[4] = 8'h00; frame(5, 3);
        rdsr(s); check("R3 dropped keeps latch", s, 8'h02);
        rd(24'h000300, 1); check("R3 array untouched", rxb[4], 8'hFF);
        send1(8'h04);

        send1(8'h06); exp_ops.push_back(3'd2);
        set_hdr(8'h20, 24'h000000); frame(4, 0);
        send1(8'h04);
        rdsr(s); check("R7 busy ignores 04h", s, 8'h03);
        wait_idle();
        rdsr(s); check("R6 erase done clears", s, 8'h00);
        send1(8'h06); exp_ops.push_back(3'd3);
        set_hdr(8'h52, 24'h000000); frame(4, 0); wait_idle();
        send1(8'h06); exp_ops.push_back(3'd4);
        set_hdr(8'hD8, 24'h000000); frame(4, 0); wait_idle();
        send1(8'h06); exp_ops.push_back(3'd5);
        send1(8'hC7); wait_idle();

        send1(8'hB9); send1(8'h06);
        rdsr(s); check("R8 asleep status quiet", s, 8'h00);
        send1(8'hAB);
        rdsr(s); check("R8 06h ignored while asleep", s, 8'h00);
        send1(8'h06);
        rdsr(s); check("R8 awake after ABh", s, 8'h02);

        exp_ops.push_back(3'd0);
        txb[0] = 8'h01; txb[1] = 8'h84; frame(2, 0);
        wait_idle();
        rdsr(s); check("R9 R11 status write", s, 8'h84);

        send1(8'h06);
        set_hdr(8'h02, 24'h0003F0); txb[4] = 8'h00; frame(5, 0);
        rdsr(s); check("R10 protected page dropped", s, 8'h86);
        send1(8'hC7);
        rdsr(s); check("R10 chip erase dropped", s, 8'h86);
        exp_ops.push_back(3'd1);
        set_hdr(8'h02, 24'h0000F0); txb[4] = 8'h0F; frame(5, 0);
        wait_idle();
        rd(24'h0000F0, 1); check("R10 open page programs", rxb[4], 8'h0F);
        rd(24'h0003F0, 1); check("R10 protected byte intact", rxb[4], 8'hFF);

        wp_n = 1'b0;
        send1(8'h06);
        txb[0] = 8'h01; txb[1] = 8'h00; frame(2, 0);
        rdsr(s); check("R9 locked write refused", s, 8'h86);
        wp_n = 1'b1;
        exp_ops.push_back(3'd0);
        txb[0] = 8'h01; txb[1] = 8'h00; frame(2, 0);
        wait_idle();
        rdsr(s); check("R9 unlocked write", s, 8'h00);

        check("R6 all expected starts seen", exp_ops.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule